// File: doc/BRIEF.md
# Integer Execute Stage for Arithmetic, Logic and Compare Instructions

This block is the execute step of a 32-bit load/store processor core. Each transfer carries a 4-bit primary opcode, a 4-bit function code, the two register operands and the 16-bit immediate field of one instruction. The block returns a result word and an effective address. It covers three groups of instructions:

- arithmetic and logic instructions, in register-register and register-immediate form, including the instruction that loads the upper half of a register;
- compare instructions, which produce 0 or 1;
- load and store instructions, for which it computes the memory address.

Fetch, the register file, program-counter updates and the memory access itself belong to other blocks.

Operands enter through a valid/ready stream, and results leave through a second valid/ready stream. A single output register sits between the two streams, so a result appears one cycle after its operands are accepted. An input transfer occurs on a rising clock edge where `in_valid` and `in_ready` are both high. An output transfer occurs on an edge where `out_valid` and `out_ready` are both high. While the consumer holds `out_ready` low, the pending result stays frozen and no new operands are taken. In the cycle the consumer drains the result, a new operand set can be accepted at the same edge.

Top module: `exu_stage`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 until the first input transfer.
- R2: `in_ready` is high exactly when the output register is empty or being drained (`!out_valid || out_ready`). An accepted transfer presents its result with `out_valid` high on the next cycle.
- R3: While `out_valid` is high and `out_ready` is low, `out_result`, `out_addr` and `out_illegal` hold their values and `out_valid` stays high.
- R4: Opcode 4'b0000 (register-register arithmetic and logic) computes A op B. The function codes are: add 0000, subtract 0001, and 0100, or 0101, xor 0110, nand 1100, nor 1101, xnor 1110. Sums and differences wrap modulo 2^32.
- R5: Opcode 4'b1000 uses the same function codes as R4, with the immediate sign-extended to 32 bits in place of B.
- R6: Under opcode 4'b1000, function 1011 puts the immediate in result bits [31:16] and zeros in bits [15:0]. A is ignored.
- R7: Opcode 4'b0010 compares A with B and writes 1 when the condition holds, else 0. Function bits [1:0] select the condition: never 00, equal 01, signed less-than 10, signed less-or-equal 11. Function bit 3 inverts the outcome, which gives always, not-equal, greater-or-equal and greater-than.
- R8: Opcode 4'b1010 is the compare of R7 with the sign-extended immediate in place of B.
- R9: Opcodes 4'b1001 (load) and 4'b0101 (store) with function 0000 return A plus the sign-extended immediate as the result. For every accepted transfer, `out_addr` is A plus the sign-extended immediate.
- R10: A function code not listed in R4 to R9 under one of the opcodes above yields result 0 and `out_illegal` = 1. For compares, this means any code with bit 2 set.
- R11: Any other opcode yields result 0 with `out_illegal` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Stage can take an operand set |
| in_opcode | input | 4 | Primary opcode |
| in_func | input | 4 | Function code |
| in_opa | input | 32 | First register operand (A) |
| in_opb | input | 32 | Second register operand (B) |
| in_imm | input | 16 | Immediate field |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Result word |
| out_addr | output | 32 | A plus sign-extended immediate |
| out_illegal | output | 1 | Unused function code under a known opcode |

## Verification
The assertions assume that the producer changes the operand fields only between edges. They also assume that `out_ready` is a clean level sampled at the rising edge, and that the result properties are looked at only in the cycle after an input transfer. The bench drives every input at the falling edge and sometimes holds `out_ready` low for several cycles while a second operand set waits. Random opcodes are drawn mostly from the six defined ones, so that the compare-width, upper-half and illegal-zero properties are all reached. Random operands and immediates cover both signs.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int OPC_W = 4;
  localparam int FN_W  = 4;

  localparam logic [OPC_W-1:0] OPC_ALU_RR = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_ALU_RI = 4'b1000;
  localparam logic [OPC_W-1:0] OPC_CMP_RR = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_CMP_RI = 4'b1010;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 4'b1001;
  localparam logic [OPC_W-1:0] OPC_STORE  = 4'b0101;

  localparam logic [FN_W-1:0] FN_ADD  = 4'b0000;
  localparam logic [FN_W-1:0] FN_SUB  = 4'b0001;
  localparam logic [FN_W-1:0] FN_AND  = 4'b0100;
  localparam logic [FN_W-1:0] FN_OR   = 4'b0101;
  localparam logic [FN_W-1:0] FN_XOR  = 4'b0110;
  localparam logic [FN_W-1:0] FN_NAND = 4'b1100;
  localparam logic [FN_W-1:0] FN_NOR  = 4'b1101;
  localparam logic [FN_W-1:0] FN_XNOR = 4'b1110;
  localparam logic [FN_W-1:0] FN_UPPER = 4'b1011;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_ALU  = 2'd1,
    CLS_CMP  = 2'd2,
    CLS_MEM  = 2'd3
  } op_class_e;

  function automatic logic alu_fn_known(input logic [FN_W-1:0] f);
    return (f == FN_ADD) || (f == FN_SUB) || (f == FN_AND) || (f == FN_OR) ||
           (f == FN_XOR) || (f == FN_NAND) || (f == FN_NOR) || (f == FN_XNOR);
  endfunction
endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  func,
  output op_class_e        op_class,
  output logic             use_imm,
  output logic             is_upper,
  output logic             illegal
);
  logic known;

  always_comb begin
    op_class = CLS_NONE;
    use_imm  = 1'b0;
    is_upper = 1'b0;
    known    = 1'b1;
    unique case (opcode)
      OPC_ALU_RR: begin
        op_class = CLS_ALU;
        known    = alu_fn_known(func);
      end
      OPC_ALU_RI: begin
        op_class = CLS_ALU;
        use_imm  = 1'b1;
        if (func == FN_UPPER) is_upper = 1'b1;
        else                  known    = alu_fn_known(func);
      end
      OPC_CMP_RR: begin
        op_class = CLS_CMP;
        known    = ~func[2];
      end
      OPC_CMP_RI: begin
        op_class = CLS_CMP;
        use_imm  = 1'b1;
        known    = ~func[2];
      end
      OPC_LOAD, OPC_STORE: begin
        op_class = CLS_MEM;
        use_imm  = 1'b1;
        known    = (func == '0);
      end
      default: begin
        op_class = CLS_NONE;
      end
    endcase
    illegal = ~known;
  end

  // decode never flags an opcode it does not own (R11)
  always_comb begin
    if (op_class == CLS_NONE) begin
      a_none_legal_r11: assert (!illegal);
    end
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [FN_W-1:0]   func,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (func)
      FN_ADD:  y = opa + opb;
      FN_SUB:  y = opa - opb;
      FN_AND:  y = opa & opb;
      FN_OR:   y = opa | opb;
      FN_XOR:  y = opa ^ opb;
      FN_NAND: y = ~(opa & opb);
      FN_NOR:  y = ~(opa | opb);
      FN_XNOR: y = ~(opa ^ opb);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/exu_cmp.sv
module exu_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [1:0]        cond,
  input  logic              invert,
  output logic              hit
);
  logic eq, lt, base;

  always_comb begin
    eq = (opa == opb);
    lt = ($signed(opa) < $signed(opb));
    unique case (cond)
      2'b00:   base = 1'b0;
      2'b01:   base = eq;
      2'b10:   base = lt;
      default: base = lt | eq;
    endcase
    hit = base ^ invert;
  end
endmodule

// File: rtl/exu_stage.sv
module exu_stage
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [OPC_W-1:0]    in_opcode,
  input  logic [FN_W-1:0]     in_func,
  input  logic [DATA_W-1:0]   in_opa,
  input  logic [DATA_W-1:0]   in_opb,
  input  logic [IMM_W-1:0]    in_imm,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_result,
  output logic [DATA_W-1:0]   out_addr,
  output logic                out_illegal
);
  localparam int EXT_W = DATA_W - IMM_W;

  op_class_e          op_class;
  logic               use_imm, is_upper, illegal;
  logic [DATA_W-1:0]  imm_sx, opb_sel, alu_y, upper_y, addr_c, result_c;
  logic               cmp_hit;
  logic               accept;

  assign imm_sx  = {{EXT_W{in_imm[IMM_W-1]}}, in_imm};
  assign opb_sel = use_imm ? imm_sx : in_opb;
  assign upper_y = {in_imm, {EXT_W{1'b0}}};
  assign addr_c  = in_opa + imm_sx;

  exu_decode u_dec (
    .opcode   (in_opcode),
    .func     (in_func),
    .op_class (op_class),
    .use_imm  (use_imm),
    .is_upper (is_upper),
    .illegal  (illegal)
  );

  exu_alu #(.DATA_W(DATA_W)) u_alu (
    .opa  (in_opa),
    .opb  (opb_sel),
    .func (in_func),
    .y    (alu_y)
  );

  exu_cmp #(.DATA_W(DATA_W)) u_cmp (
    .opa    (in_opa),
    .opb    (opb_sel),
    .cond   (in_func[1:0]),
    .invert (in_func[3]),
    .hit    (cmp_hit)
  );

  always_comb begin
    unique case (op_class)
      CLS_ALU: result_c = is_upper ? upper_y : alu_y;
      CLS_CMP: result_c = {{(DATA_W-1){1'b0}}, cmp_hit};
      CLS_MEM: result_c = addr_c;
      default: result_c = '0;
    endcase
    if (illegal) result_c = '0;
  end

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_addr    <= '0;
      out_illegal <= 1'b0;
    end else begin
      if (accept) begin
        out_valid   <= 1'b1;
        out_result  <= result_c;
        out_addr    <= addr_c;
        out_illegal <= illegal;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end

  p_accept_shows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_hold_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_result) && $stable(out_addr) && $stable(out_illegal)));

  p_cmp_single_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_opcode == OPC_CMP_RR || in_opcode == OPC_CMP_RI))
      |=> (out_result[DATA_W-1:1] == '0));

  p_upper_low_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_opcode == OPC_ALU_RI && in_func == FN_UPPER)
      |=> (out_result[EXT_W-1:0] == '0 && !out_illegal));

  p_illegal_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_result == '0));

  p_addr_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (out_addr == $past(in_opa) + {{EXT_W{$past(in_imm[IMM_W-1])}}, $past(in_imm)}));
endmodule

// File: tb/sim_exu_stage.sv
`timescale 1ns/1ps
module sim_exu_stage;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [3:0]  in_opcode;
  logic [3:0]  in_func;
  logic [31:0] in_opa;
  logic [31:0] in_opb;
  logic [15:0] in_imm;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_result;
  logic [31:0] out_addr;
  logic        out_illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  exu_stage u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_func(in_func),
    .in_opa(in_opa), .in_opb(in_opb), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_addr(out_addr), .out_illegal(out_illegal)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] logic_op(input logic [3:0] f, input logic [31:0] a,
                                           input logic [31:0] b, output bit bad);
    bad = 1'b0;
    case (f)
      4'b0000: return a + b;
      4'b0001: return a - b;
      4'b0100: return a & b;
      4'b0101: return a | b;
      4'b0110: return a ^ b;
      4'b1100: return ~(a & b);
      4'b1101: return ~(a | b);
      4'b1110: return ~(a ^ b);
      default: begin bad = 1'b1; return 32'h0; end
    endcase
  endfunction

  function automatic logic [32:0] model(input logic [3:0] op, input logic [3:0] f,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [15:0] imm);
    bit bad;
    logic [31:0] r;
    bit c;
    bad = 1'b0;
    r = 32'h0;
    case (op)
      4'b0000: r = logic_op(f, a, b, bad);
      4'b1000: if (f == 4'b1011) r = {imm, 16'h0}; else r = logic_op(f, a, sext(imm), bad);
      4'b0010, 4'b1010: begin
        logic [31:0] bb;
        bb = (op == 4'b1010) ? sext(imm) : b;
        if (f[2]) bad = 1'b1;
        else begin
          case (f[1:0])
            2'b00: c = 1'b0;
            2'b01: c = (a == bb);
            2'b10: c = ($signed(a) < $signed(bb));
            default: c = ($signed(a) <= $signed(bb));
          endcase
          r = {31'h0, c ^ f[3]};
        end
      end
      4'b1001, 4'b0101: if (f == 4'h0) r = a + sext(imm); else bad = 1'b1;
      default: r = 32'h0;
    endcase
    if (bad) r = 32'h0;
    return {bad, r};
  endfunction

  task automatic run_one(input logic [3:0] op, input logic [3:0] f, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] imm, input string req);
    logic [32:0] e;
    e = model(op, f, a, b, imm);
    @(negedge clk);
    in_valid = 1'b1; in_opcode = op; in_func = f; in_opa = a; in_opb = b; in_imm = imm;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, {req, " valid"}, {31'h0, out_valid}, 32'h1);
    check(out_result == e[31:0], {req, " result"}, out_result, e[31:0]);
    check(out_illegal == e[32], {req, " illegal"}, {31'h0, out_illegal}, {31'h0, e[32]});
    check(out_addr == a + sext(imm), "R9 addr", out_addr, a + sext(imm));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [3:0] ops [6];
    ops = '{4'b0000, 4'b1000, 4'b0010, 4'b1010, 4'b1001, 4'b0101};
    void'($urandom(32'd4711));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_opcode = '0; in_func = '0; in_opa = '0; in_opb = '0; in_imm = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 in reset", {31'h0, out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 after reset", {31'h0, out_valid}, 32'h0);
    check(in_ready == 1'b1, "R2 ready when empty", {31'h0, in_ready}, 32'h1);

    // R4 register-register corners
    run_one(4'b0000, 4'b0000, 32'h7fffffff, 32'h1, 16'h0, "R4 add overflow");
    run_one(4'b0000, 4'b0001, 32'h0, 32'h1, 16'h0, "R4 sub wrap");
    run_one(4'b0000, 4'b1100, 32'hf0f0ffff, 32'hffff0f0f, 16'h0, "R4 nand");
    run_one(4'b0000, 4'b1110, 32'h12345678, 32'h12345678, 16'h0, "R4 xnor");
    // R5 immediate sign extension
    run_one(4'b1000, 4'b0000, 32'd10, 32'hdeadbeef, 16'hffff, "R5 addi negative");
    run_one(4'b1000, 4'b0100, 32'hffffffff, 32'h0, 16'h8001, "R5 andi");
    // R6 upper half
    run_one(4'b1000, 4'b1011, 32'hffffffff, 32'h0, 16'hbeef, "R6 upper");
    // R7 compares, signed
    run_one(4'b0010, 4'b0010, 32'hffffffff, 32'h1, 16'h0, "R7 lt signed");
    run_one(4'b0010, 4'b1011, 32'h80000000, 32'h7fffffff, 16'h0, "R7 gt signed");
    run_one(4'b0010, 4'b1000, 32'h0, 32'h0, 16'h0, "R7 always");
    run_one(4'b0010, 4'b0000, 32'h5, 32'h5, 16'h0, "R7 never");
    run_one(4'b0010, 4'b0011, 32'h5, 32'h5, 16'h0, "R7 lte equal");
    // R8 immediate compare
    run_one(4'b1010, 4'b0001, 32'hffffffff, 32'h0, 16'hffff, "R8 eqi minus one");
    run_one(4'b1010, 4'b1010, 32'hfffffffe, 32'h0, 16'hffff, "R8 gtei");
    // R9 address
    run_one(4'b1001, 4'b0000, 32'h00001000, 32'h0, 16'hfffc, "R9 load");
    run_one(4'b0101, 4'b0000, 32'hf0000000, 32'h55, 16'h0004, "R9 store");
    // R10 illegal codes
    run_one(4'b0000, 4'b1011, 32'h1, 32'h2, 16'h0, "R10 alu rr 1011");
    run_one(4'b0010, 4'b0100, 32'h1, 32'h1, 16'h0, "R10 cmp bit2");
    run_one(4'b1001, 4'b0001, 32'h1, 32'h1, 16'h1, "R10 load func");
    // R11 foreign opcode
    run_one(4'b0110, 4'b0001, 32'h3, 32'h3, 16'h7, "R11 branch op");

    // R2 / R3 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_opcode = 4'b0000; in_func = 4'b0000;
    in_opa = 32'd100; in_opb = 32'd23; in_imm = 16'h0010;
    @(negedge clk);
    check(in_ready == 1'b0, "R2 not ready when stalled", {31'h0, in_ready}, 32'h0);
    in_opcode = 4'b0000; in_func = 4'b0001; in_opa = 32'd50; in_opb = 32'd8; in_imm = 16'h0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b1, "R3 valid held", {31'h0, out_valid}, 32'h1);
    check(out_result == 32'd123, "R3 result held", out_result, 32'd123);
    check(out_addr == 32'd116, "R3 addr held", out_addr, 32'd116);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_result == 32'd42, "R2 second accepted on drain", out_result, 32'd42);
    @(negedge clk);
    check(out_valid == 1'b0, "R2 drained", {31'h0, out_valid}, 32'h0);

    // random
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      logic [3:0] f;
      logic [31:0] a, b;
      logic [15:0] imm;
      op  = ($urandom % 8 == 0) ? 4'($urandom) : ops[$urandom % 6];
      f   = 4'($urandom);
      a   = $urandom;
      b   = ($urandom % 4 == 0) ? a : $urandom;
      imm = 16'($urandom);
      case (op)
        4'b0000: run_one(op, f, a, b, imm, "R4 random");
        4'b1000: run_one(op, f, a, b, imm, "R5 random");
        4'b0010: run_one(op, f, a, b, imm, "R7 random");
        4'b1010: run_one(op, f, a, b, imm, "R8 random");
        4'b1001, 4'b0101: run_one(op, f, a, b, imm, "R9 random");
        default: run_one(op, f, a, b, imm, "R11 random");
      endcase
    end
    finish_run();
  end
endmodule